// File: doc/BRIEF.md
# HDMI PLL Divider Search Engine

This block works out the divider settings for a display PLL driving an HDMI link. A pixel clock in hertz and a bits-per-component value are presented together with a one-cycle `start` pulse. The block first derives the PLL output frequency from these two inputs. It then walks a fixed, irregular list of 46 total-divider candidates, one per clock. For each candidate it forms the oscillator (DCO) frequency and keeps the legal one that lies closest to the middle of the oscillator band.

Once the scan ends, the block spends one more cycle splitting the winning divider into its P, Q and K factors. It then presents them in the encodings the PLL expects, together with the chosen DCO frequency and a found flag, and pulses `done`. The results hold their value until the next search completes. A pixel clock outside the supported window produces a not-found result with the same timing as any other search.

Top module: `hdmi_div_search`

## Requirements
- R1: A pixel clock is accepted only when it lies between 25 MHz and `MAX_PIX_HZ` (600 MHz by default), both ends inclusive. A clock outside that window yields `found`=0.
- R2: The PLL frequency is floor(bpc × 3 × pix_hz / 24). Each candidate's DCO is 5 × that frequency × the divider, and `dco_hz` reports the DCO of the chosen divider.
- R3: Candidates are scanned in the order 2,4,6,8,10,12,14,16,18,20,24,28,30,32,36,40,42,44,48,50,52,54,56,60,64,66,68,70,72,76,78,80,84,88,90,92,96,98,100,102,3,5,7,9,15,21. A DCO counts as legal within 7.998 GHz to 10 GHz inclusive. Among legal candidates the one with the smallest distance to 8.999 GHz wins, and a later candidate replaces the current best only when its distance is strictly smaller.
- R4: An even divider is factored by the first rule that applies, in this order:
  - 2 gives P=2, Q=1, K=1.
  - A multiple of 4 gives P=2, K=2, Q=div/4.
  - A multiple of 6 gives P=3, K=2, Q=div/6.
  - A multiple of 5 gives P=5, K=2, Q=div/10.
  - Any other even divider gives P=7, K=2, Q=div/14.
- R5: An odd divider of 3, 5 or 7 gives P=div, Q=1, K=1. Any other odd divider gives P=div/3, Q=1, K=3.
- R6: `p_sel` is one-hot: P=2→4'b0001, 3→4'b0010, 5→4'b0100, 7→4'b1000. `k_sel` is one-hot: K=1→3'b001, 2→3'b010, 3→3'b100. `q_div` carries Q in plain binary.
- R7: `q_mode` is 1 exactly when Q>1. Whenever K is not 2, Q equals 1.
- R8: With no legal candidate, the outputs are `found`=0, `dco_hz`=0, `p_sel`=4'b0001, `k_sel`=3'b001, `q_div`=0 and `q_mode`=0.
- R9: `done` is a one-cycle pulse, high in the cycle after the 47th rising edge that follows the edge sampling `start`. `busy` is high from the cycle after that edge until `done`, and never together with `done`.
- R10: A `start` seen while `busy` is high is ignored. The result outputs change only in the cycle where `done` is high.
- R11: After reset, `busy`, `done`, `found`, `p_sel`, `k_sel`, `q_div`, `q_mode` and `dco_hz` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a search when idle; inputs sampled on this edge |
| pix_hz | input | PIX_W (32) | Pixel clock in Hz |
| bpc | input | BPC_W (4) | Bits per colour component |
| busy | output | 1 | Search or factorisation in progress |
| done | output | 1 | One-cycle pulse when results update |
| found | output | 1 | A legal divider was found |
| p_sel | output | 4 | One-hot P divider code |
| k_sel | output | 3 | One-hot K divider code |
| q_div | output | Q_W (8) | Q divider value |
| q_mode | output | 1 | Set when Q is above 1 |
| dco_hz | output | 64 | DCO frequency of the chosen divider in Hz |

## Verification
The assertions take for granted that the 64-bit DCO products never wrap. With a 32-bit pixel clock, a 4-bit component depth and a largest divider of 102 they stay far below that limit, so the stimulus only has to keep `bpc` nonzero. They also assume that `start` may arrive at any time, so the stimulus deliberately fires a second `start` in the middle of a scan. Every vector keeps the pixel clock either inside the accepted window or one hertz past an edge of it, so that the rejection path and both inclusive boundaries are reached.

// File: rtl/hdmi_div_search.sv
module hdmi_div_search #(
  parameter int PIX_W = 32,
  parameter int BPC_W = 4,
  parameter int Q_W = 8,
  parameter longint unsigned MIN_PIX_HZ = 64'd25_000_000,
  parameter longint unsigned MAX_PIX_HZ = 64'd600_000_000,
  parameter longint unsigned DCO_LO_HZ = 64'd7_998_000_000,
  parameter longint unsigned DCO_HI_HZ = 64'd10_000_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PIX_W-1:0] pix_hz,
  input  logic [BPC_W-1:0] bpc,
  output logic             busy,
  output logic             done,
  output logic             found,
  output logic [3:0]       p_sel,
  output logic [2:0]       k_sel,
  output logic [Q_W-1:0]   q_div,
  output logic             q_mode,
  output logic [63:0]      dco_hz
);
  localparam int NCAND = 46;
  localparam int IDX_W = $clog2(NCAND);
  localparam int DIV_W = 7;
  localparam logic [63:0] DCO_MID = (DCO_LO_HZ + DCO_HI_HZ) / 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCAND - 1);

  function automatic logic [DIV_W-1:0] cand_at(input logic [IDX_W-1:0] i);
    case (i)
      6'd0:  cand_at = 7'd2;   6'd1:  cand_at = 7'd4;   6'd2:  cand_at = 7'd6;
      6'd3:  cand_at = 7'd8;   6'd4:  cand_at = 7'd10;  6'd5:  cand_at = 7'd12;
      6'd6:  cand_at = 7'd14;  6'd7:  cand_at = 7'd16;  6'd8:  cand_at = 7'd18;
      6'd9:  cand_at = 7'd20;  6'd10: cand_at = 7'd24;  6'd11: cand_at = 7'd28;
      6'd12: cand_at = 7'd30;  6'd13: cand_at = 7'd32;  6'd14: cand_at = 7'd36;
      6'd15: cand_at = 7'd40;  6'd16: cand_at = 7'd42;  6'd17: cand_at = 7'd44;
      6'd18: cand_at = 7'd48;  6'd19: cand_at = 7'd50;  6'd20: cand_at = 7'd52;
      6'd21: cand_at = 7'd54;  6'd22: cand_at = 7'd56;  6'd23: cand_at = 7'd60;
      6'd24: cand_at = 7'd64;  6'd25: cand_at = 7'd66;  6'd26: cand_at = 7'd68;
      6'd27: cand_at = 7'd70;  6'd28: cand_at = 7'd72;  6'd29: cand_at = 7'd76;
      6'd30: cand_at = 7'd78;  6'd31: cand_at = 7'd80;  6'd32: cand_at = 7'd84;
      6'd33: cand_at = 7'd88;  6'd34: cand_at = 7'd90;  6'd35: cand_at = 7'd92;
      6'd36: cand_at = 7'd96;  6'd37: cand_at = 7'd98;  6'd38: cand_at = 7'd100;
      6'd39: cand_at = 7'd102; 6'd40: cand_at = 7'd3;   6'd41: cand_at = 7'd5;
      6'd42: cand_at = 7'd7;   6'd43: cand_at = 7'd9;   6'd44: cand_at = 7'd15;
      6'd45: cand_at = 7'd21;
      default: cand_at = 7'd2;
    endcase
  endfunction

  logic             scanning, finishing, have;
  logic [IDX_W-1:0] idx;
  logic [63:0]      afe, best_dco, best_dist;
  logic [DIV_W-1:0] best_div;

  // Start-time frequency derivation; a rejected pixel clock yields a zero AFE
  logic        pix_ok;
  logic [63:0] pll_hz, afe_in;
  assign pix_ok = (64'(pix_hz) >= MIN_PIX_HZ) && (64'(pix_hz) <= MAX_PIX_HZ);
  assign pll_hz = (64'(bpc) * 64'd3 * 64'(pix_hz)) / 64'd24;
  assign afe_in = pix_ok ? pll_hz * 64'd5 : 64'd0;

  // Per-candidate scoring
  logic [DIV_W-1:0] cur_div;
  logic [63:0]      cur_dco, cur_dist;
  logic             in_band, better;
  assign cur_div  = cand_at(idx);
  assign cur_dco  = afe * 64'(cur_div);
  assign cur_dist = (cur_dco >= DCO_MID) ? cur_dco - DCO_MID : DCO_MID - cur_dco;
  assign in_band  = (cur_dco >= DCO_LO_HZ) && (cur_dco <= DCO_HI_HZ);
  assign better   = in_band && (!have || cur_dist < best_dist);

  // Factorisation of the winning divider
  logic [2:0]     p_num;
  logic [1:0]     k_num;
  logic [Q_W-1:0] q_num;
  always_comb begin
    p_num = 3'd2;
    k_num = 2'd1;
    q_num = Q_W'(1);
    if (!best_div[0]) begin
      if (best_div == 7'd2) begin
        p_num = 3'd2; k_num = 2'd1; q_num = Q_W'(1);
      end else if (best_div % 7'd4 == 7'd0) begin
        p_num = 3'd2; k_num = 2'd2; q_num = Q_W'(best_div / 7'd4);
      end else if (best_div % 7'd6 == 7'd0) begin
        p_num = 3'd3; k_num = 2'd2; q_num = Q_W'(best_div / 7'd6);
      end else if (best_div % 7'd5 == 7'd0) begin
        p_num = 3'd5; k_num = 2'd2; q_num = Q_W'(best_div / 7'd10);
      end else begin
        p_num = 3'd7; k_num = 2'd2; q_num = Q_W'(best_div / 7'd14);
      end
    end else if (best_div == 7'd3 || best_div == 7'd5 || best_div == 7'd7) begin
      p_num = best_div[2:0]; k_num = 2'd1; q_num = Q_W'(1);
    end else begin
      p_num = 3'(best_div / 7'd3); k_num = 2'd3; q_num = Q_W'(1);
    end
  end

  logic [3:0] p_code;
  logic [2:0] k_code;
  always_comb begin
    case (p_num)
      3'd3:    p_code = 4'b0010;
      3'd5:    p_code = 4'b0100;
      3'd7:    p_code = 4'b1000;
      default: p_code = 4'b0001;
    endcase
    case (k_num)
      2'd2:    k_code = 3'b010;
      2'd3:    k_code = 3'b100;
      default: k_code = 3'b001;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scanning  <= 1'b0;
      finishing <= 1'b0;
      have      <= 1'b0;
      idx       <= '0;
      afe       <= '0;
      best_dco  <= '0;
      best_dist <= '0;
      best_div  <= '0;
      done      <= 1'b0;
      found     <= 1'b0;
      p_sel     <= '0;
      k_sel     <= '0;
      q_div     <= '0;
      q_mode    <= 1'b0;
      dco_hz    <= '0;
    end else begin
      done <= 1'b0;
      if (finishing) begin
        finishing <= 1'b0;
        done      <= 1'b1;
        found     <= have;
        if (have) begin
          p_sel  <= p_code;
          k_sel  <= k_code;
          q_div  <= q_num;
          q_mode <= (q_num > Q_W'(1));
          dco_hz <= best_dco;
        end else begin
          p_sel  <= 4'b0001;
          k_sel  <= 3'b001;
          q_div  <= '0;
          q_mode <= 1'b0;
          dco_hz <= '0;
        end
      end else if (scanning) begin
        if (better) begin
          have      <= 1'b1;
          best_div  <= cur_div;
          best_dco  <= cur_dco;
          best_dist <= cur_dist;
        end
        if (idx == LAST_IDX) begin
          scanning  <= 1'b0;
          finishing <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (start) begin
        scanning <= 1'b1;
        idx      <= '0;
        have     <= 1'b0;
        afe      <= afe_in;
      end
    end
  end

  assign busy = scanning | finishing;
endmodule

module hdmi_div_search_chk #(
  parameter int Q_W = 8,
  parameter longint unsigned DCO_LO_HZ = 64'd7_998_000_000,
  parameter longint unsigned DCO_HI_HZ = 64'd10_000_000_000
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           found,
  input logic [3:0]     p_sel,
  input logic [2:0]     k_sel,
  input logic [Q_W-1:0] q_div,
  input logic           q_mode,
  input logic [63:0]    dco_hz
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  assert_onehot_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ($countones(p_sel) == 1 && $countones(k_sel) == 1));
  assert_q_when_k_not2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (found && k_sel != 3'b010) |-> q_div == Q_W'(1));
  assert_qmode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (q_mode == (q_div > Q_W'(1))));
  assert_dco_in_band_R3: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (dco_hz >= DCO_LO_HZ && dco_hz <= DCO_HI_HZ));
  assert_notfound_defaults_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (dco_hz == 64'd0 && q_div == '0 && p_sel == 4'b0001 && k_sel == 3'b001));
  assert_hold_between_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(dco_hz) && $stable(q_div) && $stable(p_sel) && $stable(k_sel) && $stable(found)));
endmodule

bind hdmi_div_search hdmi_div_search_chk #(
  .Q_W(Q_W), .DCO_LO_HZ(DCO_LO_HZ), .DCO_HI_HZ(DCO_HI_HZ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .found(found),
  .p_sel(p_sel), .k_sel(k_sel), .q_div(q_div), .q_mode(q_mode), .dco_hz(dco_hz)
);

// File: tb/tb_hdmi_div_search.sv
module tb_hdmi_div_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pix_hz = '0;
  logic [3:0]  bpc = '0;
  logic        busy, done, found, q_mode;
  logic [3:0]  p_sel;
  logic [2:0]  k_sel;
  logic [7:0]  q_div;
  logic [63:0] dco_hz;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  hdmi_div_search dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_hz(pix_hz), .bpc(bpc),
    .busy(busy), .done(done), .found(found), .p_sel(p_sel), .k_sel(k_sel),
    .q_div(q_div), .q_mode(q_mode), .dco_hz(dco_hz)
  );

  typedef struct packed {
    logic [31:0] pix;
    logic [3:0]  bpc;
    logic [3:0]  rq;
    logic        fnd;
    logic [3:0]  p;
    logic [2:0]  k;
    logic [7:0]  q;
    logic [63:0] dco;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{32'd148_500_000, 4'd8,  4'd4, 1'b1, 4'b0001, 3'b010, 8'd3,  64'd8_910_000_000}, // R4 div 12
    '{32'd594_000_000, 4'd8,  4'd5, 1'b1, 4'b0010, 3'b001, 8'd1,  64'd8_910_000_000}, // R5 div 3
    '{32'd25_200_000,  4'd8,  4'd3, 1'b1, 4'b0001, 3'b010, 8'd18, 64'd9_072_000_000}, // R3 div 72 of seven legal
    '{32'd148_500_000, 4'd10, 4'd4, 1'b1, 4'b0100, 3'b010, 8'd1,  64'd9_281_250_000}, // R4 div 10
    '{32'd128_000_000, 4'd8,  4'd4, 1'b1, 4'b1000, 3'b010, 8'd1,  64'd8_960_000_000}, // R4 div 14
    '{32'd86_000_000,  4'd8,  4'd5, 1'b1, 4'b1000, 3'b100, 8'd1,  64'd9_030_000_000}, // R5 div 21 beats 20
    '{32'd60_000_000,  4'd8,  4'd4, 1'b1, 4'b0010, 3'b010, 8'd5,  64'd9_000_000_000}, // R4 div 30
    '{32'd600_000_000, 4'd12, 4'd1, 1'b1, 4'b0001, 3'b001, 8'd1,  64'd9_000_000_000}, // R1 max edge, div 2
    '{32'd25_000_000,  4'd8,  4'd1, 1'b1, 4'b0001, 3'b010, 8'd18, 64'd9_000_000_000}, // R1 min edge
    '{32'd24_999_999,  4'd8,  4'd1, 1'b0, 4'b0001, 3'b001, 8'd0,  64'd0},             // R1 below
    '{32'd600_000_001, 4'd12, 4'd1, 1'b0, 4'b0001, 3'b001, 8'd0,  64'd0},             // R1 above
    '{32'd470_000_000, 4'd12, 4'd8, 1'b0, 4'b0001, 3'b001, 8'd0,  64'd0}              // R8 gap
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Runs one search; when poke is set, a second start with other inputs fires mid-scan
  task automatic run(input vec_t v, input bit poke, output int lat);
    @(negedge clk);
    pix_hz = v.pix; bpc = v.bpc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", 64'(busy), 64'd1);
    lat = 0;
    while (lat < 200) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (poke && lat == 10) begin
        start = 1'b1; pix_hz = 32'd470_000_000; bpc = 4'd12;
      end else begin
        start = 1'b0;
      end
      if (done) break;
    end
    start = 1'b0;
  endtask

  task automatic check_result(input vec_t v, input int lat);
    string rq;
    rq = $sformatf("R%0d", v.rq);
    chk(lat == 47, "R9", "done latency", 64'(lat), 64'd47);
    chk(found == v.fnd, rq, "found", 64'(found), 64'(v.fnd));
    chk(p_sel == v.p, rq == "R4" || rq == "R5" ? rq : "R6", "p_sel", 64'(p_sel), 64'(v.p));
    chk(k_sel == v.k, "R6", "k_sel", 64'(k_sel), 64'(v.k));
    chk(q_div == v.q, rq, "q_div", 64'(q_div), 64'(v.q));
    chk(q_mode == (v.q > 8'd1), "R7", "q_mode", 64'(q_mode), 64'(v.q > 8'd1));
    chk(dco_hz == v.dco, "R2", "dco_hz", dco_hz, v.dco);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat;
    logic [63:0] held;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(busy == 0 && done == 0 && found == 0, "R11", "flags at reset", 64'({busy, done, found}), 64'd0);
    chk(p_sel == 0 && k_sel == 0 && q_div == 0 && q_mode == 0 && dco_hz == 0, "R11", "results at reset",
        dco_hz | 64'(p_sel) | 64'(k_sel) | 64'(q_div), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      run(VECS[i], 1'b0, lat);
      check_result(VECS[i], lat);
    end

    // R10: results hold and done stays low after the pulse
    held = dco_hz;
    run(VECS[0], 1'b0, lat);
    check_result(VECS[0], lat);
    repeat (5) @(negedge clk);
    chk(done == 1'b0, "R10", "done after pulse", 64'(done), 64'd0);
    chk(busy == 1'b0, "R9", "busy when idle", 64'(busy), 64'd0);
    chk(dco_hz == 64'd8_910_000_000, "R10", "dco held", dco_hz, 64'd8_910_000_000);
    chk(held == 64'd0, "R8", "prior not-found dco", held, 64'd0);

    // R10: a start during the scan is ignored
    run(VECS[6], 1'b1, lat);
    chk(found == 1'b1, "R10", "found after mid-scan start", 64'(found), 64'd1);
    check_result(VECS[6], lat);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule